// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a scratchpad built from 32 banks that are each one 32-bit word wide. A single request carries 32 lanes. Each lane has a word address, an active flag and write data, and one read/write flag applies to the whole request. Consecutive word addresses fall in consecutive banks. A bank can deliver only one word per pass, so lanes that want different words of the same bank have to be served one after another. Lanes that want the very same word are served together from a single fetch.

The arbiter splits each request into the smallest possible number of passes. In every pass, each bank serves the word chosen by the lowest-numbered lane that is still waiting on it. Every waiting lane that wants that word is retired in that pass. Each pass takes two clock cycles: one to issue to the banks and one to collect the result. The pass count is therefore the largest number of distinct words asked of any one bank. While passes remain, `busy` is held high. Each pass is announced with a lane mask, and a one-cycle `done` pulse marks the end of the request. Read results build up in a per-lane result register. The bank storage is a plain synchronous array that lives inside the block.

Top module: `sbank_arbiter`

## Requirements
- R1: Lane address bits [4:0] select the bank and bits [9:5] select the row in that bank. Addresses are 10 bits wide, so a pattern that passes word 1023 wraps to word 0.
- R2: A request is taken only in a cycle with `req_valid` high and `busy` low. A request presented while `busy` is high is discarded and changes neither the memory nor the outputs.
- R3: A request with P ≥ 1 passes keeps `busy` high for exactly 2·P cycles and raises `pass_fire` exactly P times. Each `pass_fire` cycle is followed by a cycle with `pass_fire` low while `busy` stays high.
- R4: In each pass, a bank serves the word of its lowest-numbered pending lane. Every pending lane that asks for that same word is placed in that pass's `pass_mask`.
- R5: The pass masks of one request do not overlap, and together they equal `req_active`.
- R6: When a read request finishes, every active lane's slice of `rd_data` holds the stored word at its address. Inactive lanes keep their earlier value, and a write request leaves all of `rd_data` unchanged.
- R7: When several lanes write the same word in one pass, the data of the highest-numbered of those lanes is stored.
- R8: `done` is high for exactly one cycle, in the cycle right after `busy` falls. A request with no active lanes keeps `busy` high for one cycle and fires no pass.
- R9: After reset, `busy`, `done` and `pass_fire` are low and `rd_data` is all zeros.
- R10: P equals the largest count of distinct words asked of one bank. A column walk with a 33-word pitch takes one pass, and one with a 32-word pitch takes 32 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_active | input | 32 | Per-lane active flags |
| req_addr | input | 320 | Lane l word address in bits [10l+9:10l] |
| req_wdata | input | 1024 | Lane l write data in bits [32l+31:32l] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse after the last pass |
| pass_fire | output | 1 | A pass is issued to the banks this cycle |
| pass_mask | output | 32 | Lanes served by the pass being issued |
| rd_data | output | 1024 | Per-lane read result, lane l in bits [32l+31:32l] |

## Verification
The assertions assume that `rst_n` is asserted before the first request. They also assume that the request fields are sampled only in a cycle where `req_valid` is high and `busy` is low; nothing is assumed about those fields in other cycles. The bench drives and releases every input at falling edges. It waits for `done` before starting the next request, except in one deliberate case where a request is pushed in while busy. Before any read, the bench fills every scratchpad word through ordinary write requests, so no read ever returns an unwritten word.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  localparam int unsigned NLANE = 32;
  localparam int unsigned NBANK = 32;
  localparam int unsigned AW    = 10;
  localparam int unsigned DW    = 32;
  localparam int unsigned BW    = $clog2(NBANK);
  localparam int unsigned RW    = AW - BW;
  localparam int unsigned NROW  = 1 << RW;

  typedef logic [AW-1:0] waddr_t;
  typedef logic [BW-1:0] bank_t;
  typedef logic [RW-1:0] row_t;
  typedef logic [DW-1:0] word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RETIRE} seq_t;

  // low address bits pick the bank, the rest pick the row inside it
  function automatic bank_t bank_of(input waddr_t a);
    return a[BW-1:0];
  endfunction

  function automatic row_t row_of(input waddr_t a);
    return a[AW-1:BW];
  endfunction
endpackage

// File: rtl/sbank_pass_select.sv
module sbank_pass_select
  import sbank_pkg::*;
(
  input  logic [NLANE-1:0] pend,
  input  waddr_t           addr [NLANE],
  input  word_t            wdata [NLANE],
  output logic [NLANE-1:0] sel,
  output logic [NBANK-1:0] bank_en,
  output row_t             bank_row [NBANK],
  output word_t            bank_wdata [NBANK]
);
  waddr_t lead_addr [NBANK];

  // per bank: the lowest pending lane wins (descending scan, last hit kept)
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      bank_en[b]   = 1'b0;
      lead_addr[b] = '0;
      for (int l = NLANE - 1; l >= 0; l--) begin
        if (pend[l] && (bank_of(addr[l]) == bank_t'(b))) begin
          bank_en[b]   = 1'b1;
          lead_addr[b] = addr[l];
        end
      end
    end
  end

  // a lane rides along when it wants exactly the word its bank serves
  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      sel[l] = pend[l] && (addr[l] == lead_addr[bank_of(addr[l])]);
    end
  end

  // write data: ascending scan, so the highest selected lane wins
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      bank_row[b]   = row_of(lead_addr[b]);
      bank_wdata[b] = '0;
      for (int l = 0; l < NLANE; l++) begin
        if (sel[l] && (bank_of(addr[l]) == bank_t'(b))) begin
          bank_wdata[b] = wdata[l];
        end
      end
    end
  end
endmodule

// File: rtl/sbank_storage.sv
module sbank_storage
  import sbank_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [NBANK-1:0] en,
  input  row_t             row [NBANK],
  input  word_t            wdata [NBANK],
  output word_t            rdata [NBANK]
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    word_t mem [NROW];
    word_t q;

    always_ff @(posedge clk) begin
      if (en[b]) begin
        if (we) mem[row[b]] <= wdata[b];
        else    q           <= mem[row[b]];
      end
    end

    assign rdata[b] = q;
  end
endmodule

// File: rtl/sbank_gather.sv
module sbank_gather
  import sbank_pkg::*;
(
  input  waddr_t addr [NLANE],
  input  word_t  bank_q [NBANK],
  output word_t  lane_q [NLANE]
);
  // broadcast crossbar: each lane listens to the bank its address names
  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      lane_q[l] = bank_q[bank_of(addr[l])];
    end
  end
endmodule

// File: rtl/sbank_arbiter.sv
module sbank_arbiter
  import sbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [NLANE-1:0]    req_active,
  input  logic [NLANE*AW-1:0] req_addr,
  input  logic [NLANE*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic                pass_fire,
  output logic [NLANE-1:0]    pass_mask,
  output logic [NLANE*DW-1:0] rd_data
);
  waddr_t a_in [NLANE];
  word_t  w_in [NLANE];
  waddr_t a_q  [NLANE];
  word_t  w_q  [NLANE];
  word_t  rd_q [NLANE];
  word_t  lane_q [NLANE];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign a_in[l] = req_addr[l*AW +: AW];
    assign w_in[l] = req_wdata[l*DW +: DW];
    assign rd_data[l*DW +: DW] = rd_q[l];
  end

  seq_t             st;
  logic [NLANE-1:0] pend, sel, sel_q;
  logic             wr_q;
  logic [NBANK-1:0] bank_en, bank_go;
  row_t             bank_row [NBANK];
  word_t            bank_wd [NBANK];
  word_t            bank_q [NBANK];
  logic             accept, retire_last;

  // named events for the checks below
  assign accept      = req_valid && (st == ST_IDLE);
  assign busy        = (st != ST_IDLE);
  assign pass_fire   = (st == ST_ISSUE) && (pend != '0);
  assign pass_mask   = pass_fire ? sel : '0;
  assign bank_go     = pass_fire ? bank_en : '0;
  assign retire_last = ((pend & ~sel_q) == '0);

  sbank_pass_select u_sel (
    .pend(pend), .addr(a_q), .wdata(w_q), .sel(sel),
    .bank_en(bank_en), .bank_row(bank_row), .bank_wdata(bank_wd)
  );

  sbank_storage u_mem (
    .clk(clk), .we(wr_q), .en(bank_go), .row(bank_row),
    .wdata(bank_wd), .rdata(bank_q)
  );

  sbank_gather u_gat (
    .addr(a_q), .bank_q(bank_q), .lane_q(lane_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      pend  <= '0;
      sel_q <= '0;
      wr_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st   <= ST_ISSUE;
            pend <= req_active;
            wr_q <= req_write;
          end
        end
        ST_ISSUE: begin
          if (pend == '0) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            sel_q <= sel;
            st    <= ST_RETIRE;
          end
        end
        ST_RETIRE: begin
          pend <= pend & ~sel_q;
          if (retire_last) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q <= a_in;
      w_q <= w_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLANE; l++) rd_q[l] <= '0;
    end else if ((st == ST_RETIRE) && !wr_q) begin
      for (int l = 0; l < NLANE; l++) begin
        if (sel_q[l]) rd_q[l] <= lane_q[l];
      end
    end
  end

  // R3: a pass occupies two cycles inside the busy window
  p_pass_two_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |=> (!pass_fire && busy));

  // R4: the lowest pending lane is always served in the current pass
  p_lowest_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |-> (((pend & (-pend)) & ~pass_mask) == '0));

  // R5: a pass serves at least one lane and only pending ones
  p_mask_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |-> ((pass_mask != '0) && ((pass_mask & ~pend) == '0)));

  // R2: while busy, no new lanes are loaded
  p_no_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend & ~$past(pend)) == '0));

  // R8: done only marks the falling of busy
  p_done_marks_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/sbank_arbiter_test.sv
module sbank_arbiter_test;
  import sbank_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_write = 1'b0;
  logic [NLANE-1:0]    req_active = '0;
  logic [NLANE*AW-1:0] req_addr = '0;
  logic [NLANE*DW-1:0] req_wdata = '0;
  logic                busy, done, pass_fire;
  logic [NLANE-1:0]    pass_mask;
  logic [NLANE*DW-1:0] rd_data;

  int errs = 0;
  int checks = 0;
  word_t exp_rd [NLANE];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbank_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_active(req_active), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .pass_fire(pass_fire), .pass_mask(pass_mask),
    .rd_data(rd_data)
  );

  typedef struct packed {
    logic        alt;     // 0: base + l*stride, 1: base + (l%2)*stride
    logic [9:0]  base;
    logic [9:0]  stride;
    logic [31:0] act;
    logic [7:0]  passes;
    logic [31:0] first;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 10'd0,    10'd1,  32'hFFFFFFFF, 8'd1,  32'hFFFFFFFF},
    '{1'b0, 10'd0,    10'd33, 32'hFFFFFFFF, 8'd1,  32'hFFFFFFFF}, // R10 pitch 33
    '{1'b0, 10'd0,    10'd32, 32'hFFFFFFFF, 8'd32, 32'h00000001}, // R10 pitch 32
    '{1'b0, 10'd0,    10'd2,  32'hFFFFFFFF, 8'd2,  32'h0000FFFF},
    '{1'b0, 10'd7,    10'd0,  32'hFFFFFFFF, 8'd1,  32'hFFFFFFFF}, // multicast
    '{1'b0, 10'd0,    10'd16, 32'hFFFFFFFF, 8'd16, 32'h00000003},
    '{1'b0, 10'd0,    10'd64, 32'hFFFFFFFF, 8'd16, 32'h00010001},
    '{1'b0, 10'd5,    10'd1,  32'h0000FFFF, 8'd1,  32'h0000FFFF}, // R6 idle lanes
    '{1'b0, 10'd0,    10'd32, 32'h0000000F, 8'd4,  32'h00000001},
    '{1'b1, 10'd0,    10'd32, 32'hFFFFFFFF, 8'd2,  32'h55555555}, // R4 leader
    '{1'b1, 10'd0,    10'd32, 32'hFFFFFFFE, 8'd2,  32'hAAAAAAAA}, // R4 leader
    '{1'b0, 10'd1000, 10'd1,  32'hFFFFFFFF, 8'd1,  32'hFFFFFFFF}  // R1 wrap
  };

  function automatic word_t fval(input waddr_t a);
    return {6'h2A, a, 6'h15, a};
  endfunction

  function automatic waddr_t lane_addr(input logic alt, input logic [9:0] base,
                                       input logic [9:0] stride, input int l);
    int k;
    k = alt ? (l % 2) : l;
    return waddr_t'(int'(base) + k * int'(stride));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one request and walks it to done, sampling at falling edges
  task automatic run_req(input bit wr, input logic [31:0] act,
                         input logic [NLANE*AW-1:0] av, input logic [NLANE*DW-1:0] dv,
                         input bit inject,
                         output int ncyc, output int npass,
                         output logic [31:0] first_m, output logic [31:0] uni,
                         output bit overlap);
    bit fin;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_active = act; req_addr = av; req_wdata = dv;
    @(negedge clk);
    req_valid = 1'b0; req_active = '0; req_write = 1'b0;
    ncyc = 0; npass = 0; first_m = '0; uni = '0; overlap = 1'b0; fin = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin
        fin = 1'b1;
        break;
      end
      if (busy) ncyc++;
      if (pass_fire) begin
        if (npass == 0) first_m = pass_mask;
        if ((uni & pass_mask) != '0) overlap = 1'b1;
        uni = uni | pass_mask;
        npass++;
      end
      if (inject && ncyc == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_active = '1; req_wdata = '1;
        for (int l = 0; l < NLANE; l++) req_addr[l*AW +: AW] = waddr_t'(l);
      end else begin
        req_valid = 1'b0; req_write = 1'b0; req_active = '0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (!fin) check(1'b0, "watchdog request", 0, 1);
  endtask

  task automatic check_rd(input string req);
    int bad;
    bad = 0;
    for (int l = 0; l < NLANE; l++) begin
      if (rd_data[l*DW +: DW] !== exp_rd[l]) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int ncyc, npass;
    logic [31:0] fm, un;
    bit ov;
    logic [NLANE*AW-1:0] av;
    logic [NLANE*DW-1:0] dv;

    for (int l = 0; l < NLANE; l++) exp_rd[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(busy == 1'b0, "R9 busy", busy, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(pass_fire == 1'b0, "R9 pass_fire", pass_fire, 0);
    check(rd_data == '0, "R9 rd_data", rd_data[63:0], 0);

    // fill every word with fval(address)
    for (int r = 0; r < NROW; r++) begin
      for (int l = 0; l < NLANE; l++) begin
        av[l*AW +: AW] = waddr_t'(r * NBANK + l);
        dv[l*DW +: DW] = fval(waddr_t'(r * NBANK + l));
      end
      run_req(1'b1, '1, av, dv, 1'b0, ncyc, npass, fm, un, ov);
    end
    // R6: writes leave the result register alone
    check_rd("R6 write keeps rd_data");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int l = 0; l < NLANE; l++) begin
        av[l*AW +: AW] = lane_addr(VECS[v].alt, VECS[v].base, VECS[v].stride, l);
        dv[l*DW +: DW] = '0;
      end
      run_req(1'b0, VECS[v].act, av, dv, 1'b0, ncyc, npass, fm, un, ov);
      for (int l = 0; l < NLANE; l++) begin
        if (VECS[v].act[l]) exp_rd[l] = fval(av[l*AW +: AW]);
      end
      check(ncyc == 2 * int'(VECS[v].passes), "R3 busy cycles", ncyc, 2 * VECS[v].passes);
      check(npass == int'(VECS[v].passes), "R10 pass count", npass, VECS[v].passes);
      check(fm == VECS[v].first, "R4 first mask", fm, VECS[v].first);
      check((un == VECS[v].act) && !ov, "R5 mask cover", un, VECS[v].act);
      check_rd("R1 R6 read data");
    end

    // R8: empty request
    run_req(1'b0, '0, '0, '0, 1'b0, ncyc, npass, fm, un, ov);
    check(ncyc == 1, "R8 empty busy", ncyc, 1);
    check(npass == 0, "R8 empty passes", npass, 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done width", done, 0);
    check_rd("R8 empty keeps rd_data");

    // R2: a write pushed in while busy must be dropped
    for (int l = 0; l < NLANE; l++) av[l*AW +: AW] = waddr_t'(l * 32);
    run_req(1'b0, '1, av, '0, 1'b1, ncyc, npass, fm, un, ov);
    for (int l = 0; l < NLANE; l++) exp_rd[l] = fval(waddr_t'(l * 32));
    check(npass == 32, "R2 passes with injection", npass, 32);
    for (int l = 0; l < NLANE; l++) av[l*AW +: AW] = waddr_t'(l);
    run_req(1'b0, '1, av, '0, 1'b0, ncyc, npass, fm, un, ov);
    for (int l = 0; l < NLANE; l++) exp_rd[l] = fval(waddr_t'(l));
    check_rd("R2 memory untouched");

    // R7: all lanes write word 100, highest lane wins
    for (int l = 0; l < NLANE; l++) begin
      av[l*AW +: AW] = waddr_t'(100);
      dv[l*DW +: DW] = word_t'(32'h1000 + l);
    end
    run_req(1'b1, '1, av, dv, 1'b0, ncyc, npass, fm, un, ov);
    check(npass == 1, "R7 one pass", npass, 1);
    check_rd("R7 write keeps rd_data");
    run_req(1'b0, 32'h00000005, av, '0, 1'b0, ncyc, npass, fm, un, ov);
    exp_rd[0] = 32'h101F;
    exp_rd[2] = 32'h101F;
    check(rd_data[0 +: DW] == 32'h101F, "R7 merged word", rd_data[0 +: DW], 32'h101F);
    check_rd("R7 lanes");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule